// File: doc/BRIEF.md
# Secondary Loop Lock Status Monitor

This block derives a two-state locked/unlocked flag for a secondary digital PLL and packs it into an 8-bit read-only status byte. Four loss conditions can pull the flag low: a fine phase-error detector, a coarse detector that reports cycle slips, a no-input-activity detector, and the loop resting at its frequency floor or ceiling. Each condition has its own enable bit. The same enables also gate the primary loop's lock logic, so both loops share one set of control bits.

The coarse cycle-slip indication is held in a sticky latch. After a slip it keeps the lock flag at 0 even once the slips stop. Software clears it by driving the coarse enable low. While the enable is low, the flag follows the other enabled sources. Raising the enable again re-arms the latch. Any 1 read from the flag is therefore a current, trustworthy indication.

The status byte also carries a sync alarm, frequency soft alarms for both loops and the primary loop's operating mode. It is registered, and reset loads 0x01.

Top module: `slb_lock_monitor`

## Requirements
- R1: `sec_lock` always equals bit 6 of `status_byte`. The flag has only two states, 1 = locked and 0 = unlocked.
- R2: One clock edge after the inputs are sampled, the lock bit is 1 only if none of the enabled fine, no-activity and limit loss inputs is high.
- R3: A source whose enable is low never pulls the lock bit low, whatever its loss input does.
- R4: A one-cycle `slip_pulse` sampled while `en_coarse` is high is latched. From the second edge after the pulse, the lock bit reads 0 and stays 0 while `en_coarse` remains high, even with no further slips.
- R5: The edge that samples `en_coarse` low clears the latch. On that edge the lock bit already reflects only the other enabled sources. After `en_coarse` returns high, lock stays 1 until a new slip arrives.
- R6: A slip pulse sampled in the same cycle that `en_coarse` is low is discarded, because the clear has priority.
- R7: The status byte layout, updated one edge after its inputs are sampled, is: bit 7 `sync_alarm`, bit 6 lock, bit 5 `pri_freq_alarm`, bit 4 `sec_freq_alarm`, bits 3:0 `pri_mode`.
- R8: A synchronous active-low reset loads 0x01 into `status_byte` and clears the sticky latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; every input is synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| en_fine | input | 1 | Enable for the fine phase loss source |
| en_coarse | input | 1 | Enable for the coarse slip source; a low level clears the latch |
| en_noact | input | 1 | Enable for the no-input-activity source |
| en_limit | input | 1 | Enable for the frequency-limit source |
| fine_loss | input | 1 | Fine phase detector reports loss |
| slip_pulse | input | 1 | One-cycle pulse per detected cycle slip |
| noact_loss | input | 1 | No activity seen on the reference input |
| limit_loss | input | 1 | Loop is at its minimum or maximum frequency |
| sync_alarm | input | 1 | Sync alarm, passed to status bit 7 |
| pri_freq_alarm | input | 1 | Primary loop frequency soft alarm, passed to bit 5 |
| sec_freq_alarm | input | 1 | Secondary loop frequency soft alarm, passed to bit 4 |
| pri_mode | input | 4 | Primary loop operating mode, passed to bits 3:0 |
| status_byte | output | 8 | Registered status byte |
| sec_lock | output | 1 | Secondary loop lock flag, same as status bit 6 |

## Verification
The fine, no-activity and limit inputs, all four enables, and the pass-through alarm and mode fields reach the status byte one edge after they are sampled. A slip pulse needs two edges: one to set the latch and one to register the lock bit. Dropping `en_coarse` takes effect on the lock bit at its first edge, because the latch output is gated by the enable. The bench drives inputs just after each falling edge and updates a behavioural model at each rising edge. It compares every field at the next falling edge, so each result is checked on the cycle it is due. Directed sequences cover the slip-then-silence hold, the clear-by-toggle, a slip arriving with the enable low, and disabled sources. A stretch of random stimulus follows them.

// File: rtl/slb_pkg.sv
// Shared constants for the secondary-loop lock status monitor.
// Assumes: all loss sources are active-high and synchronous to one clock.
package slb_pkg;
    localparam int NUM_SRC    = 4;
    localparam int SRC_FINE   = 0;
    localparam int SRC_COARSE = 1;
    localparam int SRC_NOACT  = 2;
    localparam int SRC_LIMIT  = 3;

    localparam int MODE_W     = 4;
    localparam int STATUS_W   = MODE_W + 4;
    localparam int BIT_SYNC   = STATUS_W - 1;
    localparam int BIT_LOCK   = STATUS_W - 2;
    localparam int BIT_PFREQ  = STATUS_W - 3;
    localparam int BIT_SFREQ  = STATUS_W - 4;

    localparam logic [STATUS_W-1:0] STATUS_RST = {{(STATUS_W-1){1'b0}}, 1'b1};
endpackage

// File: rtl/slb_slip_latch.sv
// Sticky holder for the coarse cycle-slip loss.
// Sets on a slip pulse while the coarse enable is high, and holds.
// Clears on any edge that samples the enable low; the clear beats a slip.
// Assumes: slip_pulse and enable are synchronous to clk.
module slb_slip_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic slip,
    output logic held
);
    logic held_q;

    // Latch slips while enabled, drop everything when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= 1'b0;
        else if (!en)
            held_q <= 1'b0;
        else if (slip)
            held_q <= 1'b1;
    end

    assign held = held_q;

    AST_SLIP_SETS:  assert property (@(posedge clk) disable iff (!rst_n) (en && slip) |=> held_q);          // R4
    AST_SLIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (en && held_q) |=> held_q);        // R4
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) (!en) |=> !held_q);                // R6
endmodule

// File: rtl/slb_loss_combine.sv
// Combines the enabled loss conditions into one current lock decision.
// A source with its enable low never contributes.
// Assumes: loss and enable vectors are indexed by slb_pkg source numbers.
module slb_loss_combine
    import slb_pkg::*;
(
    input  logic [NUM_SRC-1:0] enables,
    input  logic [NUM_SRC-1:0] losses,
    output logic               lock_now
);
    logic [NUM_SRC-1:0] gated;

    // Gate each source with its own enable.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
        assign gated[s] = enables[s] & losses[s];
    end

    // Lock holds only when no gated source reports loss.
    always_comb begin
        lock_now = ~(|gated);
    end
endmodule

// File: rtl/slb_status_pack.sv
// Registers the status byte from the lock decision and pass-through fields.
// Assumes: synchronous active-low reset loads slb_pkg::STATUS_RST.
module slb_status_pack
    import slb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_now,
    input  logic                sync_alarm,
    input  logic                pri_freq_alarm,
    input  logic                sec_freq_alarm,
    input  logic [MODE_W-1:0]   pri_mode,
    output logic [STATUS_W-1:0] status
);
    logic [STATUS_W-1:0] next_status;

    // Place each field at its bit position.
    always_comb begin
        next_status                = '0;
        next_status[BIT_SYNC]      = sync_alarm;
        next_status[BIT_LOCK]      = lock_now;
        next_status[BIT_PFREQ]     = pri_freq_alarm;
        next_status[BIT_SFREQ]     = sec_freq_alarm;
        next_status[MODE_W-1:0]    = pri_mode;
    end

    // Register the byte; reset loads the fixed value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status <= STATUS_RST;
        else
            status <= next_status;
    end

    AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[MODE_W-1:0] == $past(pri_mode)));                                                 // R7
    AST_SYNC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status[BIT_SYNC] == $past(sync_alarm)));                                                 // R7
endmodule

// File: rtl/slb_lock_monitor.sv
// Top level: secondary-loop lock status monitor.
// Joins the sticky slip latch, the loss combiner and the status register.
// Assumes: all inputs are synchronous to clk; enables are shared with the primary loop.
module slb_lock_monitor
    import slb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_fine,
    input  logic                en_coarse,
    input  logic                en_noact,
    input  logic                en_limit,
    input  logic                fine_loss,
    input  logic                slip_pulse,
    input  logic                noact_loss,
    input  logic                limit_loss,
    input  logic                sync_alarm,
    input  logic                pri_freq_alarm,
    input  logic                sec_freq_alarm,
    input  logic [MODE_W-1:0]   pri_mode,
    output logic [STATUS_W-1:0] status_byte,
    output logic                sec_lock
);
    logic               slip_held;
    logic               lock_now;
    logic [NUM_SRC-1:0] enables;
    logic [NUM_SRC-1:0] losses;

    // Hold coarse slips until the enable is toggled.
    slb_slip_latch i_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en_coarse),
        .slip  (slip_pulse),
        .held  (slip_held)
    );

    // Gather enables and losses by source number.
    always_comb begin
        enables             = '0;
        losses              = '0;
        enables[SRC_FINE]   = en_fine;
        enables[SRC_COARSE] = en_coarse;
        enables[SRC_NOACT]  = en_noact;
        enables[SRC_LIMIT]  = en_limit;
        losses[SRC_FINE]    = fine_loss;
        losses[SRC_COARSE]  = slip_held;
        losses[SRC_NOACT]   = noact_loss;
        losses[SRC_LIMIT]   = limit_loss;
    end

    slb_loss_combine i_comb (
        .enables  (enables),
        .losses   (losses),
        .lock_now (lock_now)
    );

    slb_status_pack i_pack (
        .clk            (clk),
        .rst_n          (rst_n),
        .lock_now       (lock_now),
        .sync_alarm     (sync_alarm),
        .pri_freq_alarm (pri_freq_alarm),
        .sec_freq_alarm (sec_freq_alarm),
        .pri_mode       (pri_mode),
        .status         (status_byte)
    );

    assign sec_lock = status_byte[BIT_LOCK];

    AST_HELD_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (slip_held && en_coarse) |=> !sec_lock);                                                           // R4
    AST_FINE_LOSS_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fine && fine_loss) |=> !sec_lock);                                                             // R2
    AST_QUIET_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!slip_held && !(en_fine && fine_loss) && !(en_noact && noact_loss) && !(en_limit && limit_loss))
        |=> sec_lock);                                                                                     // R3
endmodule

// File: tb/test_slb_lock_monitor.sv
module test_slb_lock_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_fine = 0, en_coarse = 0, en_noact = 0, en_limit = 0;
    logic       fine_loss = 0, slip_pulse = 0, noact_loss = 0, limit_loss = 0;
    logic       sync_alarm = 0, pri_freq_alarm = 0, sec_freq_alarm = 0;
    logic [3:0] pri_mode = 4'h0;
    logic [7:0] status_byte;
    logic       sec_lock;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R8";
    logic [7:0] exp_status = 8'h01;
    bit    m_sticky = 0;
    bit    started = 0;
    bit    done = 0;

    always #4 clk = ~clk;

    slb_lock_monitor i_slb_lock_monitor (
        .clk(clk), .rst_n(rst_n),
        .en_fine(en_fine), .en_coarse(en_coarse), .en_noact(en_noact), .en_limit(en_limit),
        .fine_loss(fine_loss), .slip_pulse(slip_pulse), .noact_loss(noact_loss), .limit_loss(limit_loss),
        .sync_alarm(sync_alarm), .pri_freq_alarm(pri_freq_alarm), .sec_freq_alarm(sec_freq_alarm),
        .pri_mode(pri_mode), .status_byte(status_byte), .sec_lock(sec_lock)
    );

    // Behavioural reference, advanced on every rising edge.
    always @(posedge clk) begin
        bit lk;
        started = 1;
        cycles++;
        if (!rst_n) begin
            exp_status = 8'h01;
            m_sticky   = 0;
        end else begin
            lk = !((en_fine && fine_loss) || (en_noact && noact_loss) ||
                   (en_limit && limit_loss) || (en_coarse && m_sticky));
            exp_status = {sync_alarm, lk, pri_freq_alarm, sec_freq_alarm, pri_mode};
            if (!en_coarse) m_sticky = 0;
            else if (slip_pulse) m_sticky = 1;
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            check(cur_req, {7'b0, status_byte[6]}, {7'b0, exp_status[6]});
            check("R7", status_byte & 8'hBF, exp_status & 8'hBF);
            check("R1", {7'b0, sec_lock}, {7'b0, status_byte[6]});
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_lock(string req, bit val);
        checks++;
        if (sec_lock !== val) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", req, sec_lock, val, cycles);
        end
    endtask

    initial begin
        step(3);
        cur_req = "R8";
        checks++;
        if (status_byte !== 8'h01) begin
            errors++;
            $display("FAIL R8: actual %h expected 01", status_byte);
        end
        rst_n = 1;
        en_fine = 1; en_coarse = 1; en_noact = 1; en_limit = 1;
        step(2);
        cur_req = "R2"; expect_lock("R2", 1);
        fine_loss = 1; step(1); step(1); expect_lock("R2", 0);
        fine_loss = 0; noact_loss = 1; step(2); expect_lock("R2", 0);
        noact_loss = 0; limit_loss = 1; step(2); expect_lock("R2", 0);
        limit_loss = 0; step(2); expect_lock("R2", 1);

        cur_req = "R3";
        en_fine = 0; en_noact = 0; en_limit = 0;
        fine_loss = 1; noact_loss = 1; limit_loss = 1;
        step(3); expect_lock("R3", 1);
        en_fine = 1; en_noact = 1; en_limit = 1;
        fine_loss = 0; noact_loss = 0; limit_loss = 0;
        step(2);

        cur_req = "R4";
        slip_pulse = 1; step(1); slip_pulse = 0;
        step(1); expect_lock("R4", 0);
        step(10); expect_lock("R4", 0);

        cur_req = "R5";
        en_coarse = 0; fine_loss = 1; step(1); step(1); expect_lock("R5", 0);
        fine_loss = 0; step(2); expect_lock("R5", 1);
        en_coarse = 1; step(5); expect_lock("R5", 1);

        cur_req = "R6";
        en_coarse = 0; slip_pulse = 1; step(1);
        slip_pulse = 0; en_coarse = 1; step(4); expect_lock("R6", 1);

        cur_req = "R7";
        sync_alarm = 1; pri_freq_alarm = 0; sec_freq_alarm = 1; pri_mode = 4'hA;
        step(2);
        sync_alarm = 0; pri_freq_alarm = 1; sec_freq_alarm = 0; pri_mode = 4'h5;
        step(2);

        cur_req = "R2";
        for (int i = 0; i < 600; i++) begin
            {en_fine, en_noact, en_limit} = 3'($urandom_range(7));
            en_coarse  = ($urandom_range(9) != 0);
            fine_loss  = ($urandom_range(5) == 0);
            noact_loss = ($urandom_range(5) == 0);
            limit_loss = ($urandom_range(5) == 0);
            slip_pulse = ($urandom_range(15) == 0);
            {sync_alarm, pri_freq_alarm, sec_freq_alarm} = 3'($urandom_range(7));
            pri_mode = 4'($urandom_range(15));
            step(1);
        end

        cur_req = "R8";
        rst_n = 0; step(2);
        checks++;
        if (status_byte !== 8'h01) begin
            errors++;
            $display("FAIL R8: actual %h expected 01", status_byte);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule